// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block sits beside a small 8-bit processor core and turns twelve event inputs into one vectored interrupt request. Each source has its own pending latch. A one-cycle pulse sets the latch, and the latch then stays set until that source is serviced or the block is reset. Per-source enable bits sit in two byte-wide registers that the core writes through a simple memory-mapped write port. A fixed priority encoder picks, among the enabled pending sources, the one with the lowest index.

The core raises `ack_i` at an instruction boundary while `irq_o` is high. In that cycle the block presents the vector address of the winning source. On the clock edge that ends the cycle, it clears that source's latch and drops the global interrupt enable. Disable, enable and return-from-interrupt events from the core drive the global enable. A status byte reports the global enable and a sense bit. The sense bit shows enabled pending work even while interrupts are globally off.

Source order, highest priority first: 0 bus reset, 1 128 µs tick, 2 1 ms tick, 3–5 address A endpoints 0–2, 6–7 address B endpoints 0–1, 8 hub, 9 DAC, 10 GPIO, 11 I2C.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the global enable, all enable bits and all pending latches clear. After reset `irq_o` is 0 and `stat_o` is 0x00.
- R2: A high `src_pulse_i[i]` at a clock edge sets pending latch i. The latch stays set, whatever the enable bits are, until source i is acknowledged or reset occurs.
- R3: A write with `cfg_we_i` high at address `ENA_BASE` (0x20) loads enable bits for sources 0–7 (data bit i enables source i). A write at `ENA_BASE+1` (0x21) loads data bits 3:0 as the enables for sources 8–11. A write takes effect from the next cycle. Writes to other addresses change nothing. Clearing an enable bit does not clear the pending latch.
- R4: `irq_o` is 1 exactly when the global enable is set and at least one pending source is enabled.
- R5: Among the enabled pending sources, the lowest index wins. While `irq_o` is 1, `vec_o` equals `VEC_BASE + 2*index` of the winner and holds that value through the acknowledge cycle.
- R6: `ack_i` high together with `irq_o` clears the winner's latch and the global enable at that edge. The other latches keep their state.
- R7: `di_i` clears the global enable, and `ei_i` or `reti_i` sets it. If a clear and a set arrive in the same cycle, the clear wins. None of these events changes any latch or enable bit.
- R8: `stat_o[7]` is 1 whenever any enabled source is pending, whatever the global enable. `stat_o[2]` shows the global enable. All other status bits are 0.
- R9: A pulse on a source in the same cycle that its latch is cleared by acknowledge leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse_i | input | NSRC | Per-source event pulses |
| cfg_we_i | input | 1 | Enable-register write strobe |
| cfg_addr_i | input | ADDR_W | Write address |
| cfg_wdata_i | input | DATA_W | Write data |
| di_i | input | 1 | Disable-interrupts event |
| ei_i | input | 1 | Enable-interrupts event |
| reti_i | input | 1 | Return-from-interrupt event |
| ack_i | input | 1 | Core acknowledge at instruction boundary |
| irq_o | output | 1 | Interrupt request to core |
| vec_o | output | VEC_W | Vector address of the winning source |
| stat_o | output | 8 | Status byte: bit 7 sense, bit 2 global enable |

## Verification
The bench builds the block with twelve sources, enable registers at 0x20/0x21 and a vector base of 0x100. With a non-zero base, an addition error or a missing doubling of the index shows up in every vector compare. With twelve sources, the second enable register is only partly used, so the bit mapping across the byte boundary and priority between sources in different registers (indices 8–11 against 0–7) are both exercised.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the prioritized interrupt controller.
// Assumes status byte layout is fixed by the core's status register decode.
package irqc_pkg;
    localparam int STAT_SENSE_BIT = 7;  // sense bit position, decoded by core
    localparam int STAT_GIE_BIT   = 2;  // global enable position, decoded by core
    localparam int DEF_NSRC       = 12;
    localparam logic [7:0] DEF_ENA_BASE = 8'h20;
endpackage

// File: rtl/irqc_pend_bank.sv
// Pending latch bank: one sticky bit per source.
// Assumes set and clear are single-cycle strobes; set has priority over clear.
module irqc_pend_bank #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_bit
            // Latch a pulse; clear only on service, a same-cycle pulse wins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_o[g] <= 1'b0;
                else if (set_i[g])
                    pend_o[g] <= 1'b1;
                else if (clr_i[g])
                    pend_o[g] <= 1'b0;
            end

            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                pend_o[g] && !clr_i[g] |=> pend_o[g]);
            assert_pulse_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> pend_o[g]);
        end
    endgenerate
endmodule

// File: rtl/irqc_prio_enc.sv
// Fixed priority encoder: lowest set index wins.
// Assumes NSRC >= 2; grant is one-hot or zero.
module irqc_prio_enc #(
    parameter int NSRC  = 12,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NSRC-1:0]  grant_o
);
    // Scan from lowest priority up so the lowest index is assigned last.
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o      = IDX_W'(i);
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign valid_o = |req_i;

    always_comb begin
        assert_onehot_R5: assert ($onehot0(grant_o));
    end
endmodule

// File: rtl/irqc_gie.sv
// Global interrupt enable flag driven by core events and acknowledge.
// Assumes clear requests (ack, disable) take priority over set requests.
module irqc_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_fire_i,
    input  logic di_i,
    input  logic ei_i,
    input  logic reti_i,
    output logic gie_o
);
    // Update the flag; any clear source beats any set source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_o <= 1'b0;
        else if (ack_fire_i || di_i)
            gie_o <= 1'b0;
        else if (ei_i || reti_i)
            gie_o <= 1'b1;
    end

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire_i |=> !gie_o);
    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i || reti_i) && !ack_fire_i && !di_i |=> gie_o);
    assert_di_R7: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !gie_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: prioritized latched interrupt controller with byte-wide enable registers.
// Assumes the core asserts ack_i only at an instruction boundary; an ack
// without a live request is ignored.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          NSRC     = DEF_NSRC,
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          VEC_W    = 12,
    parameter logic [ADDR_W-1:0] ENA_BASE = ADDR_W'(DEF_ENA_BASE),
    parameter logic [VEC_W-1:0]  VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_pulse_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              di_i,
    input  logic              ei_i,
    input  logic              reti_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [7:0]        stat_o
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  ena_q;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  live;
    logic [NSRC-1:0]  grant;
    logic [NSRC-1:0]  clr;
    logic [IDX_W-1:0] win_idx;
    logic             sense;
    logic             gie;
    logic             ack_fire;
    logic             unused_wdata;

    assign unused_wdata = ^cfg_wdata_i;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_ena
            localparam int BYTE = g / DATA_W;
            localparam int BIT  = g % DATA_W;
            // Load this enable bit when its byte register is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ena_q[g] <= 1'b0;
                else if (cfg_we_i && cfg_addr_i == ENA_BASE + ADDR_W'(BYTE))
                    ena_q[g] <= cfg_wdata_i[BIT];
            end
        end
    endgenerate

    irqc_pend_bank #(.NSRC(NSRC)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_pulse_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign live = pend & ena_q;

    irqc_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) enc_i (
        .req_i   (live),
        .valid_o (sense),
        .idx_o   (win_idx),
        .grant_o (grant)
    );

    irqc_gie gie_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_fire_i (ack_fire),
        .di_i       (di_i),
        .ei_i       (ei_i),
        .reti_i     (reti_i),
        .gie_o      (gie)
    );

    // Request, acknowledge qualification and latch clear for the winner.
    assign irq_o    = gie & sense;
    assign ack_fire = ack_i & irq_o;
    assign clr      = grant & {NSRC{ack_fire}};
    assign vec_o    = VEC_BASE + VEC_W'({win_idx, 1'b0});

    // Status byte as seen by the core.
    always_comb begin
        stat_o                 = '0;
        stat_o[STAT_SENSE_BIT] = sense;
        stat_o[STAT_GIE_BIT]   = gie;
    end

    assert_req_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stat_o[STAT_GIE_BIT] && stat_o[STAT_SENSE_BIT]);
    assert_ack_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !irq_o);
    assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_i && !$past(ack_i) && $stable(live) |-> $stable(vec_o));
    assert_mask_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && !ack_fire && (|pend) |=> (|pend));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int         NSRC  = 12;
    localparam int         VEC_W = 12;
    localparam logic [11:0] VBASE = 12'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_pulse = '0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              di = 1'b0, ei = 1'b0, reti = 1'b0, ack = 1'b0;
    logic              irq;
    logic [VEC_W-1:0]  vec;
    logic [7:0]        stat;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .VEC_W(VEC_W), .ENA_BASE(8'h20), .VEC_BASE(VBASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse), .cfg_we_i(cfg_we),
        .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .di_i(di), .ei_i(ei),
        .reti_i(reti), .ack_i(ack), .irq_o(irq), .vec_o(vec), .stat_o(stat)
    );

    // Table: pulses[30:19] enables[18:7] ei[6] exp_irq[5] exp_sense[4] exp_idx[3:0]
    localparam logic [30:0] TBL [8] = '{
        {12'h001, 12'hFFF, 1'b1, 1'b1, 1'b1, 4'd0},
        {12'h800, 12'hFFF, 1'b1, 1'b1, 1'b1, 4'd11},
        {12'h0A4, 12'hFFF, 1'b1, 1'b1, 1'b1, 4'd2},
        {12'h0A4, 12'h0A0, 1'b1, 1'b1, 1'b1, 4'd5},
        {12'h0A4, 12'h000, 1'b1, 1'b0, 1'b0, 4'd0},
        {12'h300, 12'hF00, 1'b0, 1'b0, 1'b1, 4'd8},
        {12'hC00, 12'h800, 1'b1, 1'b1, 1'b1, 4'd11},
        {12'h000, 12'hFFF, 1'b1, 1'b0, 1'b0, 4'd0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic set_ena(input logic [11:0] m);
        wr(8'h20, m[7:0]);
        wr(8'h21, {4'h0, m[11:8]});
    endtask

    task automatic pulse(input logic [11:0] m);
        src_pulse = m;
        step();
        src_pulse = '0;
    endtask

    task automatic ev_ei();
        ei = 1'b1; step(); ei = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step();
        // R1: reset state
        chk("R1", "irq after reset", 32'(irq), 32'd0);
        chk("R1", "stat after reset", 32'(stat), 32'h00);

        // Table walk: R4, R5, R8
        for (int k = 0; k < 8; k++) begin
            do_reset();
            set_ena(TBL[k][18:7]);
            pulse(TBL[k][30:19]);
            if (TBL[k][6]) ev_ei();
            chk("R4", $sformatf("vec%0d irq", k), 32'(irq), 32'(TBL[k][5]));
            chk("R8", $sformatf("vec%0d sense", k), 32'(stat[7]), 32'(TBL[k][4]));
            if (TBL[k][5])
                chk("R5", $sformatf("vec%0d addr", k), 32'(vec),
                    32'(VBASE) + 32'(2 * TBL[k][3:0]));
        end

        // R1: reset clears enables; R2: latch set while masked
        do_reset();
        set_ena(12'hFFF);
        do_reset();
        pulse(12'h001);
        chk("R1", "enables cleared by reset", 32'(stat), 32'h00);
        wr(8'h20, 8'h01);
        chk("R2", "masked pulse kept pending", 32'(stat), 32'h80);

        // R6: ack clears winner latch and gie, others stay
        do_reset();
        set_ena(12'hFFF);
        pulse(12'h048);
        ev_ei();
        chk("R5", "first winner", 32'(vec), 32'(VBASE) + 32'd6);
        ack = 1'b1;
        @(posedge clk);
        chk("R5", "vector held in ack cycle", 32'(vec), 32'(VBASE) + 32'd6);
        @(negedge clk);
        ack = 1'b0;
        chk("R6", "irq after ack", 32'(irq), 32'd0);
        chk("R6", "stat after ack", 32'(stat), 32'h80);
        ev_ei();
        chk("R6", "second winner", 32'(vec), 32'(VBASE) + 32'd12);
        do_ack();
        chk("R6", "all serviced", 32'(stat), 32'h00);

        // R9: same-cycle pulse during ack keeps latch
        do_reset();
        set_ena(12'hFFF);
        pulse(12'h010);
        ev_ei();
        ack = 1'b1; src_pulse = 12'h010;
        step();
        ack = 1'b0; src_pulse = '0;
        chk("R9", "latch kept", 32'(stat), 32'h80);

        // R7: reti sets, di clears, clear beats set, latches untouched
        reti = 1'b1; step(); reti = 1'b0;
        chk("R7", "reti sets gie", 32'(stat), 32'h84);
        chk("R5", "vector after reti", 32'(vec), 32'(VBASE) + 32'd8);
        di = 1'b1; step(); di = 1'b0;
        chk("R7", "di clears gie", 32'(stat), 32'h80);
        chk("R4", "irq masked by gie", 32'(irq), 32'd0);
        ev_ei();
        di = 1'b1; ei = 1'b1; step(); di = 1'b0; ei = 1'b0;
        chk("R7", "clear beats set", 32'(stat), 32'h80);

        // R3: masking, other address, hi-register mapping
        do_reset();
        set_ena(12'hFFF);
        pulse(12'h200);
        ev_ei();
        chk("R5", "source 9 vector", 32'(vec), 32'(VBASE) + 32'd18);
        wr(8'h21, 8'h00);
        chk("R3", "mask hides source 9", 32'(stat), 32'h04);
        wr(8'h22, 8'hFF);
        chk("R3", "stray address ignored", 32'(irq), 32'd0);
        wr(8'h21, 8'h02);
        chk("R3", "unmask restores source 9", 32'(irq), 32'd1);
        chk("R3", "unmasked vector", 32'(vec), 32'(VBASE) + 32'd18);

        // R6: ack without request is ignored
        di = 1'b1; step(); di = 1'b0;
        do_ack();
        chk("R6", "ack ignored while masked", 32'(stat), 32'h80);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule